// File: doc/BRIEF.md
# Two-Dimensional Block Parity Codec

This block puts row-plus-column parity on a stream of 7-bit characters and checks it again on the far side. The transmit half takes one character per handshake, places a parity bit below the character bits to form an 8-bit row, and counts rows. After a parameterised number of data rows it sends one more row, the check row. Each bit of the check row is the parity of its column over the block's data rows. Bit 0 of the check row therefore also works as the parity of all the row parity bits. A single `odd_mode` pin picks even or odd parity. Each half reads that pin only on the first row of a block.

The receive half takes the data rows and then the check row. It checks the parity of every data row and of every column over data and check rows, and keeps the character bits in a block buffer. Once the check row has been taken it gives a one-cycle verdict pulse with an error bit, a mask of failed rows and a mask of failed columns. A block with no failure is released downstream in order, with the parity bits removed. A block with any failure is dropped whole. A start-of-block marker that comes with a row makes that row the first of a new block and discards any partial block.

All stream ports are valid/ready. A beat moves on a clock edge where both valid and ready are high. A source keeps valid high and its data stable until the beat moves. The transmit input is back-pressured while the output register is full and not being drained, and while a check row is waiting to go out. The receive input is back-pressured for as long as a clean block is being released.

Top module: `bpar_codec`

## Requirements
- R1: A transmitted data row is the character in bits 7..1 with the parity bit in bit 0. In even mode (`odd_mode`=0) the row holds an even number of ones.
- R2: In odd mode (`odd_mode`=1) every transmitted data row holds an odd number of ones.
- R3: After every ROWS data rows, exactly one check row follows, marked by `tx_out_chk`=1. Bit j of the check row is the XOR of bit j over the block's data rows in even mode, and the inverse of that in odd mode.
- R4: Each side takes the parity mode from `odd_mode` on the first row of a block. Changes to `odd_mode` on later rows of the same block have no effect.
- R5: Out of reset `tx_out_valid` is 0. While `tx_out_valid`=1 and `tx_out_ready`=0, the transmit row and its marker stay unchanged.
- R6: On receive, data row i (the i-th row after the start of a block, from 0) fails when the XOR of its 8 bits differs from the mode bit. It is then reported as bit i of `row_fail`.
- R7: Bit j of `col_fail` is set when the XOR of bit j over all data rows and the check row differs from the mode bit.
- R8: `blk_done` is 1 for exactly one cycle, the cycle after the check row is accepted. `blk_err` is 1 exactly when any bit of `row_fail` or `col_fail` is set. All three hold until the next verdict and are 0 out of reset.
- R9: After a clean verdict the ROWS characters come out on `rx_out_char` in arrival order, with `rx_out_last` on the final one only. Nothing comes out before the verdict, and `rx_in_ready` is 0 while the block is released.
- R10: A block with a failed verdict produces no output. `rx_in_ready` is 1 again in the verdict cycle.
- R11: A row accepted with `rx_in_sob`=1 becomes row 0 of a new block, and the rows received before it are discarded.
- R12: If the same two bit positions flip in two different data rows, the block still passes and the altered characters are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_mode | input | 1 | 1 = odd parity, 0 = even; read on the first row of a block |
| tx_in_valid | input | 1 | Transmit character valid |
| tx_in_ready | output | 1 | Transmit character accepted when high |
| tx_in_char | input | CHAR_W | Character to protect |
| tx_out_valid | output | 1 | Transmit row valid |
| tx_out_ready | input | 1 | Downstream can take a transmit row |
| tx_out_row | output | CHAR_W+1 | Data row or check row |
| tx_out_chk | output | 1 | 1 when the row is the check row |
| rx_in_valid | input | 1 | Received row valid |
| rx_in_ready | output | 1 | Received row accepted when high |
| rx_in_row | input | CHAR_W+1 | Received data or check row |
| rx_in_sob | input | 1 | Marks the row as the first of a block |
| rx_out_valid | output | 1 | Released character valid |
| rx_out_ready | input | 1 | Downstream can take a character |
| rx_out_char | output | CHAR_W | Released character, parity removed |
| rx_out_last | output | 1 | Final character of the block |
| blk_done | output | 1 | One-cycle verdict pulse |
| blk_err | output | 1 | Verdict: block rejected |
| row_fail | output | ROWS | Failed data rows |
| col_fail | output | CHAR_W+1 | Failed columns |

## Verification
Some properties are checked by assertions on every cycle: the stall-hold rule on both output streams, the spacing of check rows after exactly ROWS data rows, the parity of each data row sent, the single-cycle verdict pulse, and that release never happens after a failed verdict or while the input is open. The bench scenarios are the only place where actual values are compared against arithmetic expectations. These cover the value of each check row, the exact failure masks for a bit flip at every position of every row in both modes, the order and content of released characters, resynchronisation on the start marker, mode changes in the middle of a block, and the undetected rectangle pattern.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  // Receive-side phase: gather a block, or hand a clean block downstream.
  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_RELEASE = 1'b1
  } chk_phase_e;
endpackage

// File: rtl/bpar_rowbuf.sv
module bpar_rowbuf #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 7,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk)
      if (we && waddr == AW'(i)) mem[i] <= wdata;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++)
      if (raddr == AW'(i)) rdata = mem[i];
  end
endmodule

// File: rtl/bpar_enc.sv
module bpar_enc #(
  parameter int CHAR_W = 7,
  parameter int ROWS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W:0]   out_row,
  output logic              out_chk
);
  localparam int RW     = CHAR_W + 1;
  localparam int CNT_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int SEEN_W = $clog2(ROWS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             md_q, pend_q, vld_q, chk_q;
  logic [RW-1:0]    acc_q, row_q;
  logic             can_load, in_fire, first, md_now;
  logic [RW-1:0]    row_new;

  always_comb begin
    can_load = !vld_q || out_ready;
    in_ready = can_load && !pend_q;
    in_fire  = in_valid && in_ready;
    first    = (cnt_q == '0);
    md_now   = first ? odd_mode : md_q;
    row_new  = {in_char, (^in_char) ^ md_now};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      md_q   <= 1'b0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      chk_q  <= 1'b0;
      acc_q  <= '0;
      row_q  <= '0;
    end else if (in_fire) begin
      row_q <= row_new;
      chk_q <= 1'b0;
      vld_q <= 1'b1;
      md_q  <= md_now;
      acc_q <= first ? row_new : (acc_q ^ row_new);
      if (cnt_q == CNT_W'(ROWS - 1)) begin
        cnt_q  <= '0;
        pend_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (pend_q && can_load) begin
      row_q  <= acc_q ^ {RW{md_q}};
      chk_q  <= 1'b1;
      vld_q  <= 1'b1;
      pend_q <= 1'b0;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_row   = row_q;
  assign out_chk   = chk_q;

  // Data rows delivered since the last check row (supports the spacing check).
  logic [SEEN_W-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (vld_q && out_ready) seen_q <= chk_q ? '0 : seen_q + 1'b1;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !out_ready |=> vld_q && $stable(row_q) && $stable(chk_q));
  p_row_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !chk_q |-> (^row_q) == md_q);
  p_chk_after_rows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && chk_q |-> seen_q == SEEN_W'(ROWS));
  p_data_before_chk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !chk_q |-> seen_q < SEEN_W'(ROWS));
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
  import bpar_pkg::*;
#(
  parameter int CHAR_W = 7,
  parameter int ROWS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W:0]   in_row,
  input  logic              in_sob,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_last,
  output logic              done,
  output logic              err,
  output logic [ROWS-1:0]   row_fail,
  output logic [CHAR_W:0]   col_fail
);
  localparam int RW = CHAR_W + 1;
  localparam int AW = $clog2(ROWS + 1);

  chk_phase_e     ph_q;
  logic [AW-1:0]  cnt_q, rd_q, pos;
  logic           md_q, md_now, in_fire, out_fire, is_data, row_bad;
  logic [RW-1:0]  acc_q, colf_now, colf_q;
  logic [ROWS-1:0] rf_acc_q, rf_now, rowf_q;
  logic           done_q, err_q;

  always_comb begin
    in_ready = (ph_q == PH_COLLECT);
    in_fire  = in_valid && in_ready;
    pos      = in_sob ? '0 : cnt_q;
    is_data  = (pos < AW'(ROWS));
    md_now   = (pos == '0) ? odd_mode : md_q;
    row_bad  = (^in_row) != md_now;
    rf_now   = ((pos == '0) ? '0 : rf_acc_q) | ({{(ROWS-1){1'b0}}, row_bad} << pos);
    colf_now = acc_q ^ in_row ^ {RW{md_q}};
    out_fire = out_valid && out_ready;
  end

  bpar_rowbuf #(.DEPTH(ROWS), .WIDTH(CHAR_W), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (in_fire && is_data),
    .waddr (pos),
    .wdata (in_row[RW-1:1]),
    .raddr (rd_q),
    .rdata (out_char)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_COLLECT;
      cnt_q    <= '0;
      rd_q     <= '0;
      md_q     <= 1'b0;
      acc_q    <= '0;
      rf_acc_q <= '0;
      rowf_q   <= '0;
      colf_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (in_fire) begin
        if (is_data) begin
          md_q     <= md_now;
          acc_q    <= (pos == '0) ? in_row : (acc_q ^ in_row);
          rf_acc_q <= rf_now;
          cnt_q    <= pos + 1'b1;
        end else begin
          rowf_q <= rf_acc_q;
          colf_q <= colf_now;
          err_q  <= (|rf_acc_q) || (|colf_now);
          done_q <= 1'b1;
          cnt_q  <= '0;
          rd_q   <= '0;
          if (!(|rf_acc_q) && !(|colf_now)) ph_q <= PH_RELEASE;
        end
      end
      if (out_fire) begin
        if (out_last) ph_q <= PH_COLLECT;
        rd_q <= rd_q + 1'b1;
      end
    end
  end

  assign out_valid = (ph_q == PH_RELEASE);
  assign out_last  = (rd_q == AW'(ROWS - 1));
  assign done      = done_q;
  assign err       = err_q;
  assign row_fail  = rowf_q;
  assign col_fail  = colf_q;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_err_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> err_q == ((|rowf_q) || (|colf_q)));
  p_no_release_on_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !err_q);
  p_closed_while_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_char) && $stable(out_last));
  p_verdict_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(err_q) && $stable(rowf_q) && $stable(colf_q));
endmodule

// File: rtl/bpar_codec.sv
module bpar_codec #(
  parameter int CHAR_W = 7,
  parameter int ROWS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd_mode,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [CHAR_W-1:0] tx_in_char,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [CHAR_W:0]   tx_out_row,
  output logic              tx_out_chk,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [CHAR_W:0]   rx_in_row,
  input  logic              rx_in_sob,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [CHAR_W-1:0] rx_out_char,
  output logic              rx_out_last,
  output logic              blk_done,
  output logic              blk_err,
  output logic [ROWS-1:0]   row_fail,
  output logic [CHAR_W:0]   col_fail
);
  bpar_enc #(.CHAR_W(CHAR_W), .ROWS(ROWS)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .odd_mode  (odd_mode),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_char   (tx_in_char),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_row   (tx_out_row),
    .out_chk   (tx_out_chk)
  );

  bpar_chk #(.CHAR_W(CHAR_W), .ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .odd_mode  (odd_mode),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_row    (rx_in_row),
    .in_sob    (rx_in_sob),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_char  (rx_out_char),
    .out_last  (rx_out_last),
    .done      (blk_done),
    .err       (blk_err),
    .row_fail  (row_fail),
    .col_fail  (col_fail)
  );
endmodule

// File: tb/sim_bpar_codec.sv
`timescale 1ns/1ps
module sim_bpar_codec;
  localparam int ROWS = 4;
  localparam int CW   = 7;
  localparam int RW   = CW + 1;
  localparam int NTX  = 320;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, odd_mode;
  logic tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready, tx_out_chk;
  logic [CW-1:0] tx_in_char;
  logic [RW-1:0] tx_out_row;
  logic rx_in_valid, rx_in_ready, rx_in_sob, rx_out_valid, rx_out_ready, rx_out_last;
  logic [RW-1:0] rx_in_row;
  logic [CW-1:0] rx_out_char;
  logic blk_done, blk_err;
  logic [ROWS-1:0] row_fail;
  logic [RW-1:0] col_fail;

  bpar_codec #(.CHAR_W(CW), .ROWS(ROWS)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] mkrow(input logic [CW-1:0] c, input bit odd);
    return {c, (^c) ^ odd};
  endfunction

  // ---------------- transmit side collection ----------------
  logic [RW-1:0] tx_exp [NTX];
  bit            tx_exp_c [NTX];
  logic [RW-1:0] tx_got [NTX];
  bit            tx_got_c [NTX];
  int tx_exp_n = 0, tx_got_n = 0, tx_ph = 0;
  bit tx_stall = 0;
  logic [RW-1:0] tx_prev_row;
  bit tx_prev_chk;

  always @(negedge clk) begin
    tx_ph++;
    tx_out_ready = (tx_ph % 3) != 1;
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (tx_stall)  // R5: held row during back-pressure
        check(tx_out_valid && tx_out_row == tx_prev_row && tx_out_chk == tx_prev_chk,
              "R5", "stalled row changed", tx_out_row, tx_prev_row);
      if (tx_out_valid && tx_out_ready && tx_got_n < NTX) begin
        tx_got[tx_got_n]   = tx_out_row;
        tx_got_c[tx_got_n] = tx_out_chk;
        tx_got_n++;
      end
      tx_stall    = tx_out_valid && !tx_out_ready;
      tx_prev_row = tx_out_row;
      tx_prev_chk = tx_out_chk;
    end
  end

  task automatic tx_send(input logic [CW-1:0] c, input bit md);
    tx_in_valid = 1'b1;
    tx_in_char  = c;
    odd_mode    = md;
    #1;
    while (!tx_in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  // ---------------- receive side collection ----------------
  logic [RW-1:0] blk [ROWS+1];
  logic [CW-1:0] rx_got [ROWS+4];
  bit            rx_got_l [ROWS+4];
  int rx_n = 0, d_cnt = 0, early = 0;
  bit seen_done = 0, d_err = 0;
  logic [ROWS-1:0] d_rf;
  logic [RW-1:0] d_cf;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (blk_done) begin
        seen_done = 1; d_cnt++; d_err = blk_err; d_rf = row_fail; d_cf = col_fail;
      end
      if (rx_out_valid && rx_out_ready) begin
        if (!seen_done) early++;
        if (rx_n < ROWS + 4) begin
          rx_got[rx_n] = rx_out_char;
          rx_got_l[rx_n] = rx_out_last;
        end
        rx_n++;
      end
    end
  end

  task automatic rx_push(input logic [RW-1:0] row, input bit sob, input bit md);
    rx_in_valid = 1'b1;
    rx_in_row   = row;
    rx_in_sob   = sob;
    odd_mode    = md;
    #1;
    while (!rx_in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rx_in_valid = 1'b0;
    rx_in_sob   = 1'b0;
  endtask

  task automatic build(input int seed, input bit md);
    logic [RW-1:0] acc;
    acc = '0;
    for (int r = 0; r < ROWS; r++) begin
      blk[r] = mkrow(CW'((seed * 29 + r * 53 + 5) % 128), md);
      acc ^= blk[r];
    end
    blk[ROWS] = acc ^ {RW{md}};
  endtask

  // Sends blk[] (mode flipped after row 0, R4), then checks verdict and release.
  task automatic rx_run(input bit md, input bit bp, input bit exp_err,
                        input logic [ROWS-1:0] erf, input logic [RW-1:0] ecf,
                        input string req);
    seen_done = 0; d_cnt = 0; rx_n = 0; early = 0;
    rx_out_ready = 1'b1;
    for (int i = 0; i <= ROWS; i++) rx_push(blk[i], i == 0, (i == 0) ? md : !md);
    for (int k = 0; k < 16; k++) begin
      rx_out_ready = bp ? ((k % 2) == 1) : 1'b1;
      @(negedge clk);
    end
    rx_out_ready = 1'b1;
    check(d_cnt == 1, "R8", {req, " verdict pulses"}, d_cnt, 1);
    check(d_err == exp_err, "R8", {req, " blk_err"}, d_err, exp_err);
    check(d_rf == erf, "R6", {req, " row_fail"}, d_rf, erf);
    check(d_cf == ecf, "R7", {req, " col_fail"}, d_cf, ecf);
    check(blk_err == exp_err, "R8", {req, " blk_err held"}, blk_err, exp_err);
    check(rx_in_ready == 1'b1, "R10", {req, " input reopened"}, rx_in_ready, 1);
    if (exp_err) begin
      check(rx_n == 0, "R10", {req, " released count"}, rx_n, 0);
    end else begin
      check(rx_n == ROWS, "R9", {req, " released count"}, rx_n, ROWS);
      check(early == 0, "R9", {req, " output before verdict"}, early, 0);
      for (int i = 0; i < ROWS; i++) begin
        check(rx_got[i] == blk[i][RW-1:1], "R9", {req, " released char"}, rx_got[i], blk[i][RW-1:1]);
        check(rx_got_l[i] == (i == ROWS - 1), "R9", {req, " last flag"}, rx_got_l[i], i == ROWS - 1);
      end
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; odd_mode = 1'b0;
    tx_in_valid = 1'b0; tx_in_char = '0;
    rx_in_valid = 1'b0; rx_in_row = '0; rx_in_sob = 1'b0; rx_out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_out_valid == 1'b0, "R5", "reset tx_out_valid", tx_out_valid, 0);
    check(rx_out_valid == 1'b0, "R9", "reset rx_out_valid", rx_out_valid, 0);
    check(blk_done == 1'b0 && blk_err == 1'b0, "R8", "reset verdict", {blk_done, blk_err}, 0);
    check(row_fail == '0 && col_fail == '0, "R8", "reset masks", {row_fail, col_fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Transmit sweep: every character in both modes, mode pin flipped mid-block (R4).
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 32; b++) begin
        logic [RW-1:0] acc;
        acc = '0;
        for (int r = 0; r < ROWS; r++) begin
          logic [CW-1:0] c;
          c = CW'(b * ROWS + r);
          tx_exp[tx_exp_n] = mkrow(c, m[0]);
          tx_exp_c[tx_exp_n] = 1'b0;
          acc ^= tx_exp[tx_exp_n];
          tx_exp_n++;
          tx_send(c, (r == 0) ? m[0] : !m[0]);
        end
        tx_exp[tx_exp_n] = acc ^ {RW{m[0]}};
        tx_exp_c[tx_exp_n] = 1'b1;
        tx_exp_n++;
      end
    end
    for (int w = 0; w < 200; w++) if (tx_got_n < tx_exp_n) @(negedge clk);
    check(tx_got_n == tx_exp_n, "R3", "transmit beat count", tx_got_n, tx_exp_n);
    for (int i = 0; i < NTX; i++) begin
      if (i < tx_got_n) begin
        // R1 even mode rows, R2 odd mode rows, R3 check rows, R4 mode held per block
        check(tx_got[i] == tx_exp[i], tx_exp_c[i] ? "R3" : ((i < NTX / 2) ? "R1" : "R2"),
              "transmit row", tx_got[i], tx_exp[i]);
        check(tx_got_c[i] == tx_exp_c[i], "R3", "check marker", tx_got_c[i], tx_exp_c[i]);
      end
    end

    // Receive: clean blocks, then a flip at every bit of every row, both modes.
    for (int m = 0; m < 2; m++) begin
      build(100 + m, m[0]);
      rx_run(m[0], m[0], 1'b0, '0, '0, "clean");
      for (int r = 0; r <= ROWS; r++) begin
        for (int b = 0; b < RW; b++) begin
          logic [ROWS-1:0] erf;
          build(r * RW + b + m * 50, m[0]);
          blk[r][b] = !blk[r][b];
          erf = (r < ROWS) ? ROWS'(1) << r : '0;
          rx_run(m[0], 1'b0, 1'b1, erf, RW'(1) << b, "single flip");
        end
      end
      // R10: a clean block straight after a rejected one is released.
      build(77 + m, m[0]);
      rx_run(m[0], 1'b0, 1'b0, '0, '0, "after reject R10");
    end

    // Two flips inside one row: row passes, two columns fail (R7).
    build(9, 1'b0);
    blk[1][2] = !blk[1][2];
    blk[1][6] = !blk[1][6];
    rx_run(1'b0, 1'b0, 1'b1, '0, RW'(8'h44), "double flip one row R7");

    // R12: rectangle pattern goes undetected and is released.
    build(11, 1'b1);
    blk[0][1] = !blk[0][1]; blk[0][5] = !blk[0][5];
    blk[2][1] = !blk[2][1]; blk[2][5] = !blk[2][5];
    rx_run(1'b1, 1'b1, 1'b0, '0, '0, "rectangle R12");

    // R11: partial block abandoned by a new start marker.
    build(13, 1'b0);
    rx_push(8'hFF, 1'b1, 1'b0);
    rx_push(8'h01, 1'b0, 1'b0);
    rx_run(1'b0, 1'b0, 1'b0, '0, '0, "resync R11");
    build(14, 1'b1);
    rx_push(8'h80, 1'b1, 1'b1);
    rx_run(1'b1, 1'b0, 1'b0, '0, '0, "resync odd R11");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule